// File: doc/BRIEF.md
# Next Program Counter Generator

This combinational block works out the address of the next instruction for a 32-bit processor. Each cycle it receives the address of the instruction being executed, the instruction word, and the two register operands named by that instruction. It reads the 6-bit opcode in the top bits, compares the operands itself, and picks one of three address sources. The first is the sequential address, four bytes on. The second is a PC-relative branch target. The third is a jump target that keeps the upper address region of the current PC.

Conditional branches hold a signed 16-bit word offset in their low half. The offset is sign-extended, multiplied by four and added to the already-incremented PC. Jumps hold a 26-bit word address in their low bits. Scaled by four, it replaces the lower 28 bits of the PC, and the current PC supplies bits 31..28. The jump-and-link form also raises a write strobe so the caller can store the return address, which is the incremented PC.

The address source is an enumerated selection with three named values: SEQ (sequential), BRANCH (taken branch) and JUMP (jump or jump-and-link). Opcode 4 is branch-if-equal. It selects BRANCH when the operands match and SEQ when they do not. Opcode 5 is branch-if-not-equal. It selects BRANCH when the operands differ and SEQ when they match. Opcodes 2 and 3 always select JUMP. Every other opcode selects SEQ.

Top module: `npc_gen`

## Requirements
- R1: An opcode (instruction bits 31..26) other than 2, 3, 4 or 5 gives next address = PC + 4, whatever the operands.
- R2: Opcode 4 (branch-if-equal) with equal operands gives next address = PC + 4 + 4 × sign-extended bits 15..0.
- R3: A branch whose condition fails (opcode 4 with unequal operands, or opcode 5 with equal operands) gives next address = PC + 4.
- R4: Opcode 5 (branch-if-not-equal) with unequal operands gives next address = PC + 4 + 4 × sign-extended bits 15..0. For example, PC 80012 with offset 2 gives 80024.
- R5: A branch offset with bit 15 set counts as negative and moves the target backward. For example, offset 0xFFFF gives a target equal to PC.
- R6: Opcode 2 (jump) gives next address = {PC[31:28], bits 25..0, 2'b00}. For example, PC 80020 with field 20000 gives 80000.
- R7: Opcode 3 (jump-and-link) forms the same target as R6 and asserts the link strobe.
- R8: The link strobe stays low for every opcode other than 3.
- R9: The link address output always equals PC + 4.
- R10: All address sums wrap modulo 2^32. For example, PC 0xFFFFFFFC gives sequential address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| opa_i | input | 32 | First register operand for the branch compare |
| opb_i | input | 32 | Second register operand for the branch compare |
| next_pc_o | output | 32 | Selected next instruction address |
| link_addr_o | output | 32 | Return address (PC + 4) |
| link_we_o | output | 1 | High when the return address is to be written |

## Verification
The cases that are hardest to reach from the ports are the two edges of the address arithmetic. One is a negative offset that lands a branch behind itself. The other is a PC near the top of the address space, where the sums wrap and the kept upper bits of a jump are not zero. Random operands almost never compare equal, so the random stimulus forces equality on a share of vectors. The directed vectors place the PC at 0xFFFFFFFC and in the upper regions, and use offsets with bit 15 set. These cases are checked on every clock against a behavioural model.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int OPW = 6;
    localparam logic [OPW-1:0] OPC_JMP  = 6'd2;
    localparam logic [OPW-1:0] OPC_JAL  = 6'd3;
    localparam logic [OPW-1:0] OPC_BEQ  = 6'd4;
    localparam logic [OPW-1:0] OPC_BNE  = 6'd5;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } pc_src_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IMMW   = 16,
    parameter int JADDRW = 26
) (
    input  logic [XLEN-1:0]   instr_i,
    output logic              is_beq_o,
    output logic              is_bne_o,
    output logic              is_jump_o,
    output logic              is_link_o,
    output logic [IMMW-1:0]   imm_o,
    output logic [JADDRW-1:0] jaddr_o
);
    logic [OPW-1:0] opcode;

    always_comb begin
        opcode    = instr_i[XLEN-1 -: OPW];
        is_beq_o  = (opcode == OPC_BEQ);
        is_bne_o  = (opcode == OPC_BNE);
        is_link_o = (opcode == OPC_JAL);
        is_jump_o = (opcode == OPC_JMP) || (opcode == OPC_JAL);
        imm_o     = instr_i[IMMW-1:0];
        jaddr_o   = instr_i[JADDRW-1:0];
    end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic            is_beq_i,
    input  logic            is_bne_i,
    input  logic            is_jump_i,
    output pc_src_e         src_o
);
    logic same;

    always_comb begin
        same = (opa_i == opb_i);
        if (is_jump_i)
            src_o = SRC_JUMP;
        else if ((is_beq_i && same) || (is_bne_i && !same))
            src_o = SRC_BRANCH;
        else
            src_o = SRC_SEQ;
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
    parameter int XLEN   = 32,
    parameter int IMMW   = 16,
    parameter int JADDRW = 26
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [IMMW-1:0]   imm_i,
    input  logic [JADDRW-1:0] jaddr_i,
    output logic [XLEN-1:0]   seq_o,
    output logic [XLEN-1:0]   br_tgt_o,
    output logic [XLEN-1:0]   jmp_tgt_o
);
    localparam int SEXTW = XLEN - IMMW - 2;
    localparam int HIW   = XLEN - JADDRW - 2;

    logic [XLEN-1:0] offset;

    always_comb begin
        seq_o     = pc_i + XLEN'(4);
        offset    = {{SEXTW{imm_i[IMMW-1]}}, imm_i, 2'b00};
        br_tgt_o  = seq_o + offset;
        jmp_tgt_o = {pc_i[XLEN-1 -: HIW], jaddr_i, 2'b00};
    end
endmodule

// File: rtl/npc_gen.sv
module npc_gen
    import npc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IMMW   = 16,
    parameter int JADDRW = 26
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] instr_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic [XLEN-1:0] link_addr_o,
    output logic            link_we_o
);
    logic              is_beq, is_bne, is_jump, is_link;
    logic [IMMW-1:0]   imm;
    logic [JADDRW-1:0] jaddr;
    logic [XLEN-1:0]   seq, br_tgt, jmp_tgt;
    pc_src_e           src;

    npc_decode #(.XLEN(XLEN), .IMMW(IMMW), .JADDRW(JADDRW)) u_dec (
        .instr_i  (instr_i),
        .is_beq_o (is_beq),
        .is_bne_o (is_bne),
        .is_jump_o(is_jump),
        .is_link_o(is_link),
        .imm_o    (imm),
        .jaddr_o  (jaddr)
    );

    npc_cond #(.XLEN(XLEN)) u_cond (
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .is_beq_i (is_beq),
        .is_bne_i (is_bne),
        .is_jump_i(is_jump),
        .src_o    (src)
    );

    npc_targets #(.XLEN(XLEN), .IMMW(IMMW), .JADDRW(JADDRW)) u_tgt (
        .pc_i     (pc_i),
        .imm_i    (imm),
        .jaddr_i  (jaddr),
        .seq_o    (seq),
        .br_tgt_o (br_tgt),
        .jmp_tgt_o(jmp_tgt)
    );

    always_comb begin
        unique case (src)
            SRC_BRANCH: next_pc_o = br_tgt;
            SRC_JUMP:   next_pc_o = jmp_tgt;
            default:    next_pc_o = seq;
        endcase
        link_addr_o = seq;
        link_we_o   = is_link;
    end
endmodule

// File: rtl/npc_gen_chk.sv
module npc_gen_chk #(
    parameter int XLEN = 32
) (
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] instr_i,
    input logic [XLEN-1:0] opa_i,
    input logic [XLEN-1:0] opb_i,
    input logic [XLEN-1:0] next_pc_o,
    input logic [XLEN-1:0] link_addr_o,
    input logic            link_we_o
);
    logic [5:0] op;
    logic       branch_fails;

    always_comb begin
        op = instr_i[XLEN-1 -: 6];
        branch_fails = ((op == 6'd4) && (opa_i != opb_i)) ||
                       ((op == 6'd5) && (opa_i == opb_i));
        // R1: unknown opcodes fall through to the sequential address
        if (!(op inside {6'd2, 6'd3, 6'd4, 6'd5}))
            p_other_seq_r1: assert (next_pc_o == link_addr_o)
                else $error("next address not sequential for opcode %0d", op);
        // R3: a failed branch falls through
        if (branch_fails)
            p_not_taken_r3: assert (next_pc_o == link_addr_o)
                else $error("failed branch left the sequence");
        // R6: jumps keep the upper PC bits and land word-aligned
        if (op == 6'd2 || op == 6'd3)
            p_jump_region_r6: assert (next_pc_o[XLEN-1 -: 4] == pc_i[XLEN-1 -: 4]
                                      && next_pc_o[1:0] == 2'b00)
                else $error("jump left its region");
        // R8: link strobe only for jump-and-link
        if (link_we_o)
            p_link_only_jal_r8: assert (op == 6'd3)
                else $error("link strobe on opcode %0d", op);
        // R9: link value is the sequential address
        p_link_addr_r9: assert (link_addr_o - pc_i == XLEN'(4))
            else $error("link address wrong");
    end
endmodule

bind npc_gen npc_gen_chk #(.XLEN(XLEN)) u_chk (
    .pc_i       (pc_i),
    .instr_i    (instr_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .next_pc_o  (next_pc_o),
    .link_addr_o(link_addr_o),
    .link_we_o  (link_we_o)
);

// File: tb/tb_npc_gen.sv
module tb_npc_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc, instr, opa, opb;
    logic [31:0] next_pc, link_addr;
    logic        link_we;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    npc_gen dut (
        .pc_i       (pc),
        .instr_i    (instr),
        .opa_i      (opa),
        .opb_i      (opb),
        .next_pc_o  (next_pc),
        .link_addr_o(link_addr),
        .link_we_o  (link_we)
    );

    function automatic logic [31:0] mk_i(int op, longint low);
        return 32'((longint'(op) << 26) | (low & 64'h3FFFFFF));
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference, compared every clock
    task automatic apply(string req, logic [31:0] p, logic [31:0] ins,
                         logic [31:0] a, logic [31:0] b);
        longint seq, tgt;
        int     op, off;
        logic   we;
        @(posedge clk);
        pc = p; instr = ins; opa = a; opb = b;
        op  = int'(ins[31:26]);
        off = int'($signed(ins[15:0]));
        seq = (longint'(p) + 4) % 64'h1_0000_0000;
        tgt = seq;
        we  = 1'b0;
        case (op)
            2, 3: begin
                tgt = (longint'(p) / 64'h1000_0000) * 64'h1000_0000
                      + longint'(ins[25:0]) * 4;
                we  = (op == 3);
            end
            4: if (a == b) tgt = seq + longint'(off) * 4;
            5: if (a != b) tgt = seq + longint'(off) * 4;
            default: ;
        endcase
        tgt = tgt & 64'hFFFF_FFFF;
        @(negedge clk);
        check(req, "next", next_pc, 32'(tgt));
        check(req, "link", link_addr, 32'(seq));
        check(req, "we", {31'd0, link_we}, {31'd0, we});
    endtask

    initial begin
        pc = 0; instr = 0; opa = 0; opb = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero word behaves as a plain opcode (R1, R8)
        apply("R1", 32'd0, 32'd0, 32'd0, 32'd0);
        apply("R1", 32'd100, mk_i(35, 64'h1234), 32'd1, 32'd1);
        apply("R2", 32'd400, mk_i(4, 16'd7), 32'hAA, 32'hAA);
        apply("R3", 32'd400, mk_i(4, 16'd7), 32'hAA, 32'hAB);
        apply("R3", 32'd400, mk_i(5, 16'd7), 32'h5, 32'h5);
        apply("R4", 32'd80012, mk_i(5, 16'd2), 32'd1, 32'd2);
        check("R4", "example", next_pc, 32'd80024);
        apply("R5", 32'd80012, mk_i(5, 16'hFFFF), 32'd0, 32'd9);
        check("R5", "self", next_pc, 32'd80012);
        apply("R5", 32'd4096, mk_i(4, 16'h8000), 32'd3, 32'd3);
        apply("R6", 32'd80020, mk_i(2, 20000), 32'd0, 32'd0);
        check("R6", "example", next_pc, 32'd80000);
        apply("R6", 32'hA000_0040, mk_i(2, 64'h3FF_FFFF), 32'd0, 32'd0);
        apply("R7", 32'h7000_1000, mk_i(3, 64'h10), 32'd1, 32'd2);
        check("R7", "strobe", {31'd0, link_we}, 32'd1);
        apply("R8", 32'd64, mk_i(2, 5), 32'd1, 32'd1);
        check("R8", "strobe", {31'd0, link_we}, 32'd0);
        apply("R9", 32'h1234_5678, mk_i(9, 0), 32'd0, 32'd0);
        apply("R10", 32'hFFFF_FFFC, mk_i(0, 0), 32'd0, 32'd0);
        check("R10", "wrap", next_pc, 32'd0);
        apply("R10", 32'hFFFF_FFF0, mk_i(4, 16'd10), 32'd6, 32'd6);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b, ins;
            int op;
            op  = (i % 4 == 0) ? int'($urandom_range(0, 63)) : int'($urandom_range(2, 5));
            ins = {6'(op), 26'($urandom)};
            a   = $urandom;
            b   = (i % 3 == 0) ? a : 32'($urandom);
            apply("R1-R10 random", 32'($urandom) & 32'hFFFF_FFFC, ins, a, b);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule